// File: doc/BRIEF.md
# UART Receive FIFO with Status

This block is the receive data path of one memory-mapped serial channel. Bytes arrive from a serial deserializer as single-cycle strobes. They are stored in a circular buffer whose depth is set per channel by the `DEPTH` parameter, which may be 16, 64 or 256. A small register window is served over a word address. It holds a control word, a line status word with the data-ready bit, a FIFO status word, and the receive data port. Reading the data port removes the oldest byte.

With the buffer disabled, the channel falls back to a single holding register. Each new byte overwrites that register. The block drives two one-cycle flags for a neighbouring interrupt block: one for every accepted byte, and one for error conditions (a byte lost to a full buffer, or a read of an empty buffer). It also drives the receive and transmit trigger levels and a transmit-flush pulse. The transmit count and transmit full flag come in from the transmit side only so that they can be shown in the FIFO status word.

Top module: `uart_rxq`

## Requirements
- R1: After synchronous reset the control word reads 0, the line status word reads 0, and the FIFO status word shows receive count 0 with both receive flags clear. `rx_event`, `err_event` and `tx_flush` are low.
- R2: Word addresses are 0 control, 1 line status, 2 FIFO status and 3 receive data. With control bit 0 set (buffer enabled), bytes read from address 3 come out in arrival order, and each read removes one byte.
- R3: In buffered mode, FIFO status bits 7:0 give the number of stored bytes. Line status bit 0 is 1 while at least one byte is stored and 0 once the last byte has been read.
- R4: When the buffer holds `DEPTH` bytes, FIFO status bit 8 is 1 and bits 7:0 read 0.
- R5: A byte that arrives while the buffer is full is discarded, and `err_event` pulses in the next cycle. FIFO status bit 9 is then set and stays set until a receive flush.
- R6: In buffered mode, a read of address 3 while the buffer is empty returns 0, and `err_event` pulses in the next cycle.
- R7: `rx_event` pulses for one cycle, the cycle after each accepted byte. It does not pulse for a discarded byte.
- R8: With control bit 0 clear, each received byte overwrites a holding register and sets line status bit 0. A read of address 3 returns the held byte and clears bit 0. Such a read never raises `err_event`.
- R9: Writing control bit 1 empties the receive buffer and clears status bit 9. Writing control bit 2 raises `tx_flush` during that write. Both bits read back as 0, while bit 0, bits 6:4 and bits 10:8 read back as written.
- R10: `rx_trig_lvl` equals control bits 6:4 times DEPTH/8, and `tx_trig_lvl` equals control bits 10:8 times DEPTH/8. This gives a multiplier of 32, 8 or 2 for depths 256, 64 and 16.
- R11: A byte accepted in the same cycle as a data read leaves the stored count unchanged.
- R12: FIFO status bits 23:16 show `tx_fill` and bit 24 shows `tx_full`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 3) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| tx_fill | input | 8 | Transmit buffer count, shown in the FIFO status word |
| tx_full | input | 1 | Transmit buffer full, shown in the FIFO status word |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the cycle of the strobe |
| rx_event | output | 1 | Pulse: a byte was accepted |
| err_event | output | 1 | Pulse: a byte was discarded, or an empty buffer was read |
| tx_flush | output | 1 | Transmit flush request during a control write |
| rx_trig_lvl | output | 8 | Receive trigger level |
| tx_trig_lvl | output | 8 | Transmit trigger level |

## Verification
The assertions assume three things about the inputs. `reg_rd` and `reg_wr` are never raised in the same cycle. A receive flush never coincides with an arriving byte. `DEPTH` is one of the three supported sizes, so that the count field and the pointers wrap correctly. The stimulus drives each strobe for exactly one cycle from the falling edge and only ever raises one register strobe at a time. It issues flushes only while the receive strobe is low, so every checked cycle stays inside these assumptions.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_LSTAT = 2'd1,
        RA_FSTAT = 2'd2,
        RA_DATA  = 2'd3
    } rxq_addr_e;

    localparam int EN_BIT       = 0;
    localparam int RX_FLUSH_BIT = 1;
    localparam int TX_FLUSH_BIT = 2;
    localparam int RX_TRIG_LSB  = 4;
    localparam int TX_TRIG_LSB  = 8;

    localparam int FST_RX_FULL  = 8;
    localparam int FST_RX_ERR   = 9;
    localparam int FST_TX_LSB   = 16;
    localparam int FST_TX_FULL  = 24;

    typedef struct packed {
        logic [2:0] tx_trig;
        logic [2:0] rx_trig;
        logic       fifo_en;
    } rxq_ctrl_t;

    // scale a 3-bit trigger field by depth/8
    function automatic logic [7:0] trig_level(input logic [2:0] field, input int depth);
        return 8'(int'(field) * (depth / 8));
    endfunction

    function automatic logic [31:0] ctrl_to_word(input rxq_ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[EN_BIT] = c.fifo_en;
        w[RX_TRIG_LSB +: 3] = c.rx_trig;
        w[TX_TRIG_LSB +: 3] = c.tx_trig;
        return w;
    endfunction

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign dout  = mem[rptr];

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(push && full && !pop));

    // R11
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !flush) |=> $stable(count));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import uart_rxq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output rxq_ctrl_t   ctrl,
    output logic        rx_flush,
    output logic        tx_flush
);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[31:11], wdata[7], wdata[3]};

    // flush bits act during the write and are never stored
    assign rx_flush = wr_en && wdata[RX_FLUSH_BIT];
    assign tx_flush = wr_en && wdata[TX_FLUSH_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl.fifo_en <= wdata[EN_BIT];
            ctrl.rx_trig <= wdata[RX_TRIG_LSB +: 3];
            ctrl.tx_trig <= wdata[TX_TRIG_LSB +: 3];
        end
    end

    // R9
    ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl.fifo_en == $past(wdata[EN_BIT])) &&
                  (ctrl.rx_trig == $past(wdata[RX_TRIG_LSB +: 3])));

endmodule

// File: rtl/rxq_regmux.sv
module rxq_regmux
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          rst,
    input  logic [1:0]    addr,
    input  rxq_ctrl_t     ctrl,
    input  logic          ready,
    input  logic [CW-1:0] count,
    input  logic          full,
    input  logic          err_sticky,
    input  logic [7:0]    tx_fill,
    input  logic          tx_full,
    input  logic [31:0]   data_word,
    output logic [31:0]   rdata
);

    logic [31:0] fstat;

    always_comb begin
        fstat = '0;
        fstat[7:0]              = full ? 8'd0 : 8'(count);
        fstat[FST_RX_FULL]      = full;
        fstat[FST_RX_ERR]       = err_sticky;
        fstat[FST_TX_LSB +: 8]  = tx_fill;
        fstat[FST_TX_FULL]      = tx_full;
    end

    always_comb begin
        case (rxq_addr_e'(addr))
            RA_CTRL:  rdata = ctrl_to_word(ctrl);
            RA_LSTAT: rdata = {31'd0, ready};
            RA_FSTAT: rdata = fstat;
            default:  rdata = data_word;
        endcase
    end

    // R4
    always_comb begin
        if (!rst && full) begin
            full_zero_chk: assert (fstat[7:0] == 8'd0 && fstat[FST_RX_FULL]);
        end
    end

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic [7:0]  tx_fill,
    input  logic        tx_full,
    output logic [31:0] reg_rdata,
    output logic        rx_event,
    output logic        err_event,
    output logic        tx_flush,
    output logic [7:0]  rx_trig_lvl,
    output logic [7:0]  tx_trig_lvl
);

    rxq_ctrl_t     ctrl;
    logic          rx_flush;
    logic          push, pop, drop, under;
    logic [7:0]    q_dout;
    logic [CW-1:0] q_count;
    logic          q_empty, q_full;
    logic [7:0]    hold_byte;
    logic          hold_rdy;
    logic          err_sticky;
    logic          ready;
    logic          rd_data;
    logic [31:0]   data_word;

    rxq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr && (rxq_addr_e'(reg_addr) == RA_CTRL)),
        .wdata    (reg_wdata),
        .ctrl     (ctrl),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush)
    );

    assign rd_data = reg_rd && (rxq_addr_e'(reg_addr) == RA_DATA);
    assign push    = ctrl.fifo_en && rx_valid && !q_full && !rx_flush;
    assign drop    = ctrl.fifo_en && rx_valid &&  q_full && !rx_flush;
    assign pop     = ctrl.fifo_en && rd_data && !q_empty && !rx_flush;
    assign under   = ctrl.fifo_en && rd_data && q_empty;

    rxq_ring #(.DEPTH(DEPTH), .DW(8)) u_ring (
        .clk   (clk),
        .rst   (rst),
        .flush (rx_flush),
        .push  (push),
        .pop   (pop),
        .din   (rx_byte),
        .dout  (q_dout),
        .count (q_count),
        .empty (q_empty),
        .full  (q_full)
    );

    // bypass holding register and event flags
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_byte  <= '0;
            hold_rdy   <= 1'b0;
            err_sticky <= 1'b0;
            rx_event   <= 1'b0;
            err_event  <= 1'b0;
        end else begin
            if (!ctrl.fifo_en && rx_valid) begin
                hold_byte <= rx_byte;
                hold_rdy  <= 1'b1;
            end else if (!ctrl.fifo_en && rd_data) begin
                hold_rdy  <= 1'b0;
            end
            if (rx_flush)  err_sticky <= 1'b0;
            else if (drop) err_sticky <= 1'b1;
            rx_event  <= push || (!ctrl.fifo_en && rx_valid);
            err_event <= drop || under;
        end
    end

    assign ready = ctrl.fifo_en ? !q_empty : hold_rdy;

    always_comb begin
        if (!ctrl.fifo_en)  data_word = {24'd0, hold_byte};
        else if (q_empty)   data_word = '0;
        else                data_word = {24'd0, q_dout};
    end

    rxq_regmux #(.DEPTH(DEPTH)) u_mux (
        .rst        (rst),
        .addr       (reg_addr),
        .ctrl       (ctrl),
        .ready      (ready),
        .count      (q_count),
        .full       (q_full),
        .err_sticky (err_sticky),
        .tx_fill    (tx_fill),
        .tx_full    (tx_full),
        .data_word  (data_word),
        .rdata      (reg_rdata)
    );

    assign rx_trig_lvl = trig_level(ctrl.rx_trig, DEPTH);
    assign tx_trig_lvl = trig_level(ctrl.tx_trig, DEPTH);

    // R5
    drop_err_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.fifo_en && rx_valid && q_full && !rx_flush) |=> err_event);

    // R6
    under_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data && ctrl.fifo_en && q_empty) |-> (reg_rdata == 32'd0));

    // R8
    bypass_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.fifo_en && rx_valid) |=> hold_rdy);

    // R7
    rx_event_src_chk: assert property (@(posedge clk) disable iff (rst)
        rx_event |-> $past(rx_valid));

endmodule

// File: tb/uart_rxq_tb.sv
`timescale 1ns/1ps
module uart_rxq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  tx_fill = 8'h05;
    logic        tx_full = 1'b1;
    logic [31:0] reg_rdata, w_rdata;
    logic        rx_event, err_event, tx_flush;
    logic        w_rx_event, w_err_event, w_tx_flush;
    logic [7:0]  rx_trig_lvl, tx_trig_lvl, w_rx_trig, w_tx_trig;

    int checks = 0;
    int errors = 0;
    logic        last_txf;
    logic [31:0] rd;

    localparam logic [31:0] TXP = 32'h0105_0000;

    always #2.5 clk = ~clk;

    uart_rxq #(.DEPTH(16)) u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .tx_fill(tx_fill), .tx_full(tx_full), .reg_rdata(reg_rdata),
        .rx_event(rx_event), .err_event(err_event), .tx_flush(tx_flush),
        .rx_trig_lvl(rx_trig_lvl), .tx_trig_lvl(tx_trig_lvl)
    );

    uart_rxq #(.DEPTH(64)) u_dut_wide (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .tx_fill(tx_fill), .tx_full(tx_full), .reg_rdata(w_rdata),
        .rx_event(w_rx_event), .err_event(w_err_event), .tx_flush(w_tx_flush),
        .rx_trig_lvl(w_rx_trig), .tx_trig_lvl(w_tx_trig)
    );

    // {op, addr, data, expected, req}; op 0 push, 1 write, 2 read-compare
    localparam int NV = 15;
    localparam logic [71:0] VEC [NV] = '{
        {2'd1, 2'd0, 32'h0000_0001, 32'h0,          4'd2},  // R2 enable buffer
        {2'd0, 2'd0, 32'h0000_0011, 32'h0,          4'd7},  // R7 push
        {2'd0, 2'd0, 32'h0000_0022, 32'h0,          4'd7},
        {2'd0, 2'd0, 32'h0000_0033, 32'h0,          4'd7},
        {2'd2, 2'd2, 32'h0,         32'h0105_0003,  4'd3},  // R3 count 3
        {2'd2, 2'd1, 32'h0,         32'h0000_0001,  4'd3},  // R3 ready
        {2'd2, 2'd3, 32'h0,         32'h0000_0011,  4'd2},  // R2 order
        {2'd2, 2'd3, 32'h0,         32'h0000_0022,  4'd2},
        {2'd2, 2'd3, 32'h0,         32'h0000_0033,  4'd2},
        {2'd2, 2'd1, 32'h0,         32'h0000_0000,  4'd3},  // R3 ready clears
        {2'd2, 2'd2, 32'h0,         32'h0105_0000,  4'd3},
        {2'd1, 2'd0, 32'h0000_0351, 32'h0,          4'd9},  // R9 fields
        {2'd2, 2'd0, 32'h0,         32'h0000_0351,  4'd9},
        {2'd1, 2'd0, 32'h0000_0357, 32'h0,          4'd9},  // R9 reset bits
        {2'd2, 2'd0, 32'h0,         32'h0000_0351,  4'd9}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        #1 last_txf = tx_flush;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rdreg(2'd0, rd); check("R1 ctrl", rd, 32'h0);
        rdreg(2'd1, rd); check("R1 lstat", rd, 32'h0);
        rdreg(2'd2, rd); check("R1 fstat", rd, TXP);
        check("R1 events", {29'd0, rx_event, err_event, tx_flush}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [71:0] v;
            v = VEC[i];
            case (v[71:70])
                2'd0: push(v[43:36]);
                2'd1: wr(v[69:68], v[67:36]);
                default: begin
                    rdreg(v[69:68], rd);
                    check($sformatf("R%0d vec%0d", v[3:0], i), rd, v[35:4]);
                end
            endcase
        end

        // R10 trigger scaling: rx field 5, tx field 3
        check("R10 rx16", {24'd0, rx_trig_lvl}, 32'd10);
        check("R10 tx16", {24'd0, tx_trig_lvl}, 32'd6);
        check("R10 rx64", {24'd0, w_rx_trig}, 32'd40);
        check("R10 tx64", {24'd0, w_tx_trig}, 32'd24);

        // R7 event on accepted byte
        push(8'h41);
        check("R7 rx_event", {31'd0, rx_event}, 32'd1);

        // R11 simultaneous push and pop
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h42; reg_rd = 1'b1; reg_addr = 2'd3;
        #1 check("R11 data", reg_rdata, 32'h41);
        @(negedge clk);
        rx_valid = 1'b0; reg_rd = 1'b0;
        rdreg(2'd2, rd); check("R11 count", rd, TXP | 32'd1);
        rdreg(2'd3, rd); check("R11 second", rd, 32'h42);

        // R4 fill to depth
        for (int i = 0; i < 16; i++) push(8'(8'h80 + i));
        rdreg(2'd2, rd); check("R4 full", rd, TXP | 32'h100);
        // R5 overflow
        push(8'hEE);
        check("R5 err_event", {31'd0, err_event}, 32'd1);
        check("R7 no rx_event on drop", {31'd0, rx_event}, 32'd0);
        rdreg(2'd2, rd); check("R5 sticky", rd, TXP | 32'h300);
        for (int i = 0; i < 16; i++) begin
            rdreg(2'd3, rd);
            check("R5 order after drop", rd, 32'(8'h80 + i));
        end
        rdreg(2'd1, rd); check("R3 drained", rd, 32'h0);

        // R6 read empty
        rdreg(2'd3, rd);
        check("R6 zero", rd, 32'h0);
        check("R6 err_event", {31'd0, err_event}, 32'd1);

        // R9 flush
        push(8'h01); push(8'h02);
        wr(2'd0, 32'h0000_0353);
        rdreg(2'd2, rd); check("R9 flushed", rd, TXP);
        rdreg(2'd1, rd); check("R9 not ready", rd, 32'h0);
        check("R9 no tx_flush", {31'd0, last_txf}, 32'd0);
        wr(2'd0, 32'h0000_0355);
        check("R9 tx_flush", {31'd0, last_txf}, 32'd1);

        // R8 bypass
        wr(2'd0, 32'h0);
        push(8'h5C);
        rdreg(2'd1, rd); check("R8 ready", rd, 32'h1);
        rdreg(2'd3, rd); check("R8 data", rd, 32'h5C);
        check("R8 no err", {31'd0, err_event}, 32'd0);
        rdreg(2'd1, rd); check("R8 ready cleared", rd, 32'h0);
        push(8'h61); push(8'h62);
        rdreg(2'd3, rd); check("R8 overwrite", rd, 32'h62);

        // R12 transmit passthrough
        tx_fill = 8'hC3; tx_full = 1'b0;
        rdreg(2'd2, rd); check("R12 tx fields", rd, 32'h00C3_0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule